// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one active-low external interrupt pin into a latched interrupt request for a CPU. The pin first passes through a two-flop synchronizer. A falling edge on the synchronized level sets a request latch. The CPU sees the latch, gated by a mask, on its request line. Software reaches a single 8-bit status/control register over a simple peripheral bus with address, read strobe, write strobe and data lines. Through that register it reads the pending flag, sets the mask, picks the trigger mode and acknowledges the request.

Two trigger modes are offered. In edge mode, a vector fetch from the CPU or a software acknowledge drops the latch at once. In edge-plus-level mode, the latch cannot be cleared while the pin is still held low. The flag always shows the latch, whatever the mask is set to, so polling works with the request masked.

An outside break controller drives a break-state input and a break-clear-enable input. While the break state is active and clearing is not enabled, acknowledge writes leave the latch alone, so a debugger can inspect pending state. The synchronized pin level is also brought out so the CPU can test the pin directly.

Top module: `ext_irq_pin_ctrl`

## Requirements
- R1: The register sits at bus address REG_ADDR (default 0). A read there returns bit 3 = pending flag, bit 1 = mask, bit 0 = mode, and bit 2 (acknowledge) and bits 7..4 always 0. When no read of that address is under way, busRdata is 0. A write to any other address changes nothing.
- R2: After reset, the flag, mask and mode are all 0, the register reads 0x00 and cpuIrq is 0.
- R3: pinLevel follows irqPinN two clock edges late. The latch is set at the third rising edge after a falling pin transition.
- R4: In edge mode (mode = 0), only a falling edge sets the latch. A pin held low does not set it again after it has been cleared.
- R5: In edge mode, a one-cycle vecFetch pulse, or a register write with bit 2 = 1, clears the latch at that clock edge.
- R6: In level mode (mode = 1), an acknowledge write or a vecFetch leaves the latch set while the synchronized pin is low. The same acknowledge clears it once the synchronized pin is high.
- R7: The flag shows the latch regardless of the mask. cpuIrq equals flag AND NOT mask. A write sets the mask from bit 1 and the mode from bit 0.
- R8: While brkActive = 1 and brkClrEn = 0, an acknowledge write has no effect on the latch.
- R9: While brkActive = 1 and brkClrEn = 1, an acknowledge write clears the latch. The latch stays clear after brkActive returns to 0.
- R10: When a new falling edge and a clear request land on the same clock edge, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPinN | input | 1 | External active-low interrupt pin (asynchronous) |
| busAddr | input | ADDR_W | Register address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, 0 when not reading the register |
| vecFetch | input | 1 | CPU vector-fetch acknowledge pulse |
| brkActive | input | 1 | Debug break state is active |
| brkClrEn | input | 1 | Allow latch clearing during break |
| cpuIrq | output | 1 | Interrupt request to the CPU |
| pinLevel | output | 1 | Synchronized pin level |

## Verification
The pin is driven with isolated falling pulses, long low holds across clears, and back-to-back falls that arrive while a clear is written. These separate edge triggering from level holding and show the edge-wins rule. Each pattern runs in both modes and with the mask on and off, so a flag tied to the mask, or a clear that ignores the pin in level mode, shows up as a mismatch. Acknowledge writes are repeated with the break state active, with and without the clear enable, and at a wrong address, to separate the protected clear, the permitted clear and the ignored write.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W    = 8;
  localparam int MODE_BIT = 0;
  localparam int MASK_BIT = 1;
  localparam int ACK_BIT  = 2;
  localparam int FLAG_BIT = 3;

  typedef struct packed {
    logic wrCtl;    // load mask and mode
    logic newMask;
    logic newMode;
    logic clrReq;   // clear request, already qualified by break rules
  } ctlStrobe_t;
endpackage

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              vecFetch,
  input  logic              brkActive,
  input  logic              brkClrEn,
  input  logic              flag,
  input  logic              mask,
  input  logic              mode,
  output ctlStrobe_t        strb,
  output logic [REG_W-1:0]  busRdata
);
  localparam logic [ADDR_W-1:0] REG_SEL = ADDR_W'(REG_ADDR);

  logic addrHit;
  logic wrHit;
  logic ackAllowed;
  logic ackWrite;

  assign addrHit    = (busAddr == REG_SEL);
  assign wrHit      = busWr & addrHit;
  assign ackAllowed = ~brkActive | brkClrEn;
  assign ackWrite   = wrHit & busWdata[ACK_BIT];

  always_comb begin
    strb.wrCtl   = wrHit;
    strb.newMask = busWdata[MASK_BIT];
    strb.newMode = busWdata[MODE_BIT];
    strb.clrReq  = vecFetch | (ackWrite & ackAllowed);
  end

  always_comb begin
    busRdata = '0;
    if (busRd && addrHit) begin
      busRdata[FLAG_BIT] = flag;
      busRdata[MASK_BIT] = mask;
      busRdata[MODE_BIT] = mode;
    end
  end
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqPinN,
  input  ctlStrobe_t strb,
  output logic       latch,
  output logic       mask,
  output logic       mode,
  output logic       pinLevel,
  output logic       fallEdge
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic prevLevel;
  logic clrOk;
  logic latchNext;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= irqPinN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[i] <= 1'b1;
          else       syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  assign pinLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b1;
    else       prevLevel <= pinLevel;
  end

  assign fallEdge  = prevLevel & ~pinLevel;
  // level mode refuses a clear while the pin is still low
  assign clrOk     = strb.clrReq & (~mode | pinLevel);
  assign latchNext = fallEdge | (latch & ~clrOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latch <= 1'b0;
      mask  <= 1'b0;
      mode  <= 1'b0;
    end else begin
      latch <= latchNext;
      if (strb.wrCtl) begin
        mask <= strb.newMask;
        mode <= strb.newMode;
      end
    end
  end

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> latch);

  // R6
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode && latch && !pinLevel) |=> latch);

  // R5
  edge_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mode && latch && strb.clrReq && !fallEdge) |=> !latch);
endmodule

// File: rtl/ext_irq_pin_ctrl.sv
module ext_irq_pin_ctrl
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int REG_ADDR    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqPinN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              vecFetch,
  input  logic              brkActive,
  input  logic              brkClrEn,
  output logic              cpuIrq,
  output logic              pinLevel
);
  ctlStrobe_t strb;
  logic latch;
  logic mask;
  logic mode;
  logic fallEdge;

  ext_irq_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .vecFetch(vecFetch), .brkActive(brkActive), .brkClrEn(brkClrEn),
    .flag(latch), .mask(mask), .mode(mode),
    .strb(strb), .busRdata(busRdata)
  );

  ext_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .strb(strb),
    .latch(latch), .mask(mask), .mode(mode),
    .pinLevel(pinLevel), .fallEdge(fallEdge)
  );

  assign cpuIrq = latch & ~mask;

  // R1
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> (busRdata[7:4] == 4'h0 && !busRdata[ACK_BIT]));

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    mask |-> !cpuIrq);

  // R8
  brk_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkActive && !brkClrEn && !vecFetch && busWr && busWdata[ACK_BIT] && latch)
      |=> latch);

  // R9
  brk_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkActive && brkClrEn && busWr && busAddr == ADDR_W'(REG_ADDR) &&
     busWdata[ACK_BIT] && !mode && !fallEdge) |=> !latch);
endmodule

// File: tb/tb_ext_irq_pin_ctrl.sv
module tb_ext_irq_pin_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqPinN = 1'b1;
  logic [3:0] busAddr = 4'h0;
  logic busRd = 1'b0;
  logic busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic vecFetch = 1'b0;
  logic brkActive = 1'b0;
  logic brkClrEn = 1'b0;
  logic cpuIrq;
  logic pinLevel;

  int nChecks = 0;
  int nFail = 0;

  ext_irq_pin_ctrl dut (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .vecFetch(vecFetch), .brkActive(brkActive), .brkClrEn(brkClrEn),
    .cpuIrq(cpuIrq), .pinLevel(pinLevel)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pin history and behavioural latch
  bit hist[3];
  bit mLatch, mMask, mMode;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = '{1'b1, 1'b1, 1'b1};
      mLatch = 0; mMask = 0; mMode = 0;
    end else begin
      bit edgeNow, lvl, wrHit, clr;
      lvl = hist[1];
      edgeNow = hist[2] && !hist[1];
      wrHit = busWr && busAddr == 4'h0;
      clr = vecFetch || (wrHit && busWdata[2] && (!brkActive || brkClrEn));
      if (mMode) mLatch = edgeNow || (mLatch && !(clr && lvl));
      else       mLatch = edgeNow || (mLatch && !clr);
      if (wrHit) begin mMask = busWdata[1]; mMode = busWdata[0]; end
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = irqPinN;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rstN) begin
      check("R3 pinLevel vs model", pinLevel, hist[1]);
      check("R7 cpuIrq vs model", cpuIrq, mLatch && !mMask);
      check("R1 idle busRdata", busRdata, 0);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] v);
    busAddr = a; busRd = 1'b1;
    #1 v = busRdata;
    busRd = 1'b0; busAddr = 4'h0;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    tick();
    busWr = 1'b0; busWdata = 8'h00; busAddr = 4'h0;
  endtask

  task automatic expFlag(input string tag, input bit exp);
    logic [7:0] v;
    readReg(4'h0, v);
    check(tag, v[3], exp);
  endtask

  task automatic fallPin();   // high settle then fall; flag set after 3 ticks
    irqPinN = 1'b1; tick(4);
    irqPinN = 1'b0; tick(3);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(3);
    readReg(4'h0, v);
    check("R2 reset register", v, 8'h00);
    check("R2 reset cpuIrq", cpuIrq, 0);
    rstN = 1'b1;
    tick(2);

    // R1 layout and write-only / unimplemented bits
    writeReg(4'h0, 8'hFF);
    readReg(4'h0, v);
    check("R1 readback after 0xFF", v, 8'h03);
    readReg(4'h5, v);
    check("R1 other address reads 0", v, 8'h00);
    writeReg(4'h0, 8'h00);
    writeReg(4'h7, 8'h03);
    readReg(4'h0, v);
    check("R1 wrong-address write ignored", v, 8'h00);

    // R3 synchronizer latency
    irqPinN = 1'b0; tick();
    check("R3 pinLevel after 1 edge", pinLevel, 1);
    tick();
    check("R3 pinLevel after 2 edges", pinLevel, 0);
    expFlag("R3 flag before 3rd edge", 0);
    tick();
    expFlag("R3 flag after 3rd edge", 1);
    check("R7 cpuIrq unmasked", cpuIrq, 1);

    // R5 ack clear, R4 held low does not re-set
    writeReg(4'h0, 8'h04);
    expFlag("R5 ack clears", 0);
    tick(5);
    expFlag("R4 held low no re-set", 0);
    fallPin();
    expFlag("R4 new fall sets", 1);
    vecFetch = 1'b1; tick(); vecFetch = 1'b0;
    expFlag("R5 vecFetch clears", 0);

    // R7 mask does not hide the flag
    writeReg(4'h0, 8'h02);
    fallPin();
    expFlag("R7 flag with mask", 1);
    check("R7 cpuIrq masked", cpuIrq, 0);
    writeReg(4'h0, 8'h00);
    check("R7 cpuIrq after unmask", cpuIrq, 1);
    writeReg(4'h0, 8'h04);

    // R6 level mode
    writeReg(4'h0, 8'h01);
    fallPin();
    expFlag("R6 level mode set", 1);
    writeReg(4'h0, 8'h05);
    expFlag("R6 ack while low ignored", 1);
    vecFetch = 1'b1; tick(); vecFetch = 1'b0;
    expFlag("R6 vecFetch while low ignored", 1);
    irqPinN = 1'b1; tick(2);
    expFlag("R6 still set after pin high", 1);
    writeReg(4'h0, 8'h05);
    expFlag("R6 ack clears once high", 0);

    // R8 / R9 break behaviour in edge mode
    writeReg(4'h0, 8'h00);
    fallPin();
    expFlag("R8 setup", 1);
    brkActive = 1'b1; brkClrEn = 1'b0;
    writeReg(4'h0, 8'h04);
    expFlag("R8 protected ack ignored", 1);
    brkClrEn = 1'b1;
    writeReg(4'h0, 8'h04);
    expFlag("R9 enabled ack clears", 0);
    brkActive = 1'b0; brkClrEn = 1'b0;
    tick(3);
    expFlag("R9 stays clear after break", 0);

    // R10 edge wins over clear
    fallPin();
    irqPinN = 1'b1; tick(4);
    expFlag("R10 setup latch held", 1);
    irqPinN = 1'b0; tick(2);
    writeReg(4'h0, 8'h04);
    expFlag("R10 edge beats ack", 1);
    irqPinN = 1'b1; tick(4);
    irqPinN = 1'b0; tick(2);
    vecFetch = 1'b1; tick(); vecFetch = 1'b0;
    expFlag("R10 edge beats vecFetch", 1);

    irqPinN = 1'b1; tick(4);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule